// File: doc/BRIEF.md
# Interrupt Priority Filter with Binary Point

This block is the signalling stage for one processor. It looks at a set of interrupt sources. Each source has a pending bit, an enable bit, an active bit and an 8-bit priority, where a smaller value means a more urgent interrupt. Among the sources that are pending and enabled, it picks the one with the smallest priority value. That source wins only if its priority is strictly below a threshold. The threshold is the priority mask register with its low bits cleared, and the binary point setting decides how many low bits are cleared.

The winner's number is presented on `irq_id`. When nothing qualifies, `irq_id` carries the spurious identifier. The request line `irq_req` rises only when four conditions hold: the global distributor enable is set, the processor interface enable is set, a winner exists, and that winner is not already active.

The output side is a two-state machine, and both states are registered:
- `ST_QUIET`: the request line is low.
- `ST_SIGNAL`: the request line is high.

Every clock edge takes one of four transitions:
- `ST_QUIET` goes to `ST_SIGNAL` when the raise condition holds.
- `ST_SIGNAL` goes to `ST_QUIET` when it no longer holds.
- `ST_QUIET` and `ST_SIGNAL` each hold otherwise.

The selected number is captured on the same edge.

Software sets up the block through a small register port. `cfg_sel` picks the register and `cfg_we` writes `cfg_wdata`. `cfg_rdata` reads back the register that `cfg_sel` selects, without delay.

Top module: `irq_prio_gate`

## Requirements
- R1: After reset, `irq_req` is 0 and `irq_id` is 1023. Reading back gives: control 0x00, priority mask 0xFF, binary point 2.
- R2: A write to select 2 (binary point) keeps only `cfg_wdata[2:0]`. A kept value below 2 is stored as 2. Read-back returns the stored value.
- R3: The threshold is the mask with bits [bp:0] cleared. For example, bp 2 gives mask & 0xF8, bp 4 gives mask & 0xE0, and bp 7 gives 0x00.
- R4: The winner is the source with the smallest priority among those that are pending and enabled. Its priority must be strictly less than the threshold. A source whose priority equals the threshold does not qualify.
- R5: When priorities are equal, the lowest-numbered source wins.
- R6: When no source qualifies, `irq_id` is 1023 and `irq_req` is 0.
- R7: `irq_req` is 1 only if both enable bits are set: control bit 0 (distributor enable) and control bit 1 (interface enable), written at select 0. `irq_id` still shows the winner when either enable is clear.
- R8: If the winner's active bit is set, `irq_req` stays 0 and `irq_id` still shows the winner.
- R9: `irq_req` and `irq_id` change on the first rising edge after an input or register change, and not before.
- R10: Select 1 holds the priority mask and reads it back. Select 3 reads 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 mask, 2 binary point, 3 none |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read-back of the selected register |
| src_pend | input | NUM_SRC | Pending bit per source |
| src_en | input | NUM_SRC | Enable bit per source |
| src_act | input | NUM_SRC | Active bit per source |
| src_prio | input | NUM_SRC*8 | Priorities, source i at bits [8i+7:8i] |
| irq_req | output | 1 | Registered interrupt request |
| irq_id | output | 10 | Registered selected source number, or 1023 |

## Verification
The bench builds the block with its default of 32 sources, so source numbers fill five of the ten identifier bits. The bench steps through binary point writes of 0 to 7 with different masks, and for each one it scans random priorities against its own reference. At these default values every threshold width can be reached, including the floor clamp and the all-blocking threshold at bp 7. Directed cases cover the exact threshold boundary, ties, both enables, the active bit, and the one-cycle output latency.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef enum logic {
        ST_QUIET  = 1'b0,
        ST_SIGNAL = 1'b1
    } irq_state_e;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_MASK = 2'd1;
    localparam logic [1:0] SEL_BP   = 2'd2;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
    parameter int PW     = 8,
    parameter int BP_MIN = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [1:0]    sel,
    input  logic [PW-1:0] wdata,
    output logic [PW-1:0] rdata,
    output logic          dist_en,
    output logic          cpu_en,
    output logic [PW-1:0] pmask,
    output logic [2:0]    bp
);
    import irq_pkg::*;

    localparam logic [2:0] BP_FLOOR = 3'(BP_MIN);

    logic [2:0] bp_in;

    always_comb begin
        bp_in = wdata[2:0];
        if (bp_in < BP_FLOOR) bp_in = BP_FLOOR;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dist_en <= 1'b0;
            cpu_en  <= 1'b0;
            pmask   <= '1;
            bp      <= BP_FLOOR;
        end else if (we) begin
            unique case (sel)
                SEL_CTRL: begin
                    dist_en <= wdata[0];
                    cpu_en  <= wdata[1];
                end
                SEL_MASK: pmask <= wdata;
                SEL_BP:   bp    <= bp_in;
                default:  ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        unique case (sel)
            SEL_CTRL: rdata = PW'({cpu_en, dist_en});
            SEL_MASK: rdata = pmask;
            SEL_BP:   rdata = PW'(bp);
            default:  rdata = '0;
        endcase
    end

    assert_bp_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bp >= BP_FLOOR);

    assert_bp_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == SEL_BP && wdata[2:0] >= BP_FLOOR) |=> bp == $past(wdata[2:0]));
endmodule

// File: rtl/irq_thresh.sv
module irq_thresh #(
    parameter int PW = 8
) (
    input  logic [PW-1:0] pmask,
    input  logic [2:0]    bp,
    output logic [PW-1:0] thresh
);
    logic [PW-1:0] keep;

    for (genvar b = 0; b < PW; b++) begin : g_keep
        assign keep[b] = (b > int'(bp));
    end

    assign thresh = pmask & keep;
endmodule

// File: rtl/irq_prio_scan.sv
module irq_prio_scan #(
    parameter int N  = 32,
    parameter int PW = 8,
    parameter int IW = 10
) (
    input  logic [N-1:0]    pend,
    input  logic [N-1:0]    en,
    input  logic [N-1:0]    act,
    input  logic [N*PW-1:0] prio,
    input  logic [PW-1:0]   thresh,
    output logic            found,
    output logic [IW-1:0]   win_id,
    output logic            win_act,
    output logic [PW-1:0]   win_prio
);
    logic [PW-1:0] prio_a [N];

    for (genvar i = 0; i < N; i++) begin : g_split
        assign prio_a[i] = prio[i*PW +: PW];
    end

    always_comb begin
        found    = 1'b0;
        win_id   = '0;
        win_act  = 1'b0;
        win_prio = thresh;
        for (int i = 0; i < N; i++) begin
            if (pend[i] && en[i] && (prio_a[i] < win_prio)) begin
                found    = 1'b1;
                win_prio = prio_a[i];
                win_id   = IW'(i);
                win_act  = act[i];
            end
        end
    end
endmodule

// File: rtl/irq_prio_gate.sv
module irq_prio_gate #(
    parameter int NUM_SRC  = 32,
    parameter int PW       = 8,
    parameter int IW       = 10,
    parameter int SPURIOUS = 1023,
    parameter int BP_MIN   = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [1:0]            cfg_sel,
    input  logic [PW-1:0]         cfg_wdata,
    output logic [PW-1:0]         cfg_rdata,
    input  logic [NUM_SRC-1:0]    src_pend,
    input  logic [NUM_SRC-1:0]    src_en,
    input  logic [NUM_SRC-1:0]    src_act,
    input  logic [NUM_SRC*PW-1:0] src_prio,
    output logic                  irq_req,
    output logic [IW-1:0]         irq_id
);
    import irq_pkg::*;

    localparam logic [IW-1:0] SPUR_ID = IW'(SPURIOUS);

    logic          dist_en, cpu_en;
    logic [PW-1:0] pmask, thresh, win_prio;
    logic [2:0]    bp;
    logic          found, win_act, raise;
    logic [IW-1:0] win_id;
    irq_state_e    state_q, state_d;

    irq_cfg_regs #(.PW(PW), .BP_MIN(BP_MIN)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
        .wdata(cfg_wdata), .rdata(cfg_rdata),
        .dist_en(dist_en), .cpu_en(cpu_en), .pmask(pmask), .bp(bp)
    );

    irq_thresh #(.PW(PW)) u_thresh (
        .pmask(pmask), .bp(bp), .thresh(thresh)
    );

    irq_prio_scan #(.N(NUM_SRC), .PW(PW), .IW(IW)) u_scan (
        .pend(src_pend), .en(src_en), .act(src_act), .prio(src_prio),
        .thresh(thresh), .found(found), .win_id(win_id),
        .win_act(win_act), .win_prio(win_prio)
    );

    assign raise = found && dist_en && cpu_en && !win_act;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET:  if (raise)  state_d = ST_SIGNAL;
            ST_SIGNAL: if (!raise) state_d = ST_QUIET;
            default:   state_d = ST_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_QUIET;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_id <= SPUR_ID;
        else        irq_id <= found ? win_id : SPUR_ID;
    end

    assign irq_req = (state_q == ST_SIGNAL);

    assert_spurious_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_id == SPUR_ID) |-> !irq_req);

    assert_req_needs_enables_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> $past(dist_en && cpu_en));

    assert_active_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (found && win_act) |=> !irq_req);

    assert_below_thresh_R4: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (win_prio < thresh));
endmodule

// File: tb/irq_prio_gate_test.sv
`timescale 1ns/1ps
module irq_prio_gate_test;
    localparam int N = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_we = 1'b0;
    logic [1:0]   cfg_sel = '0;
    logic [7:0]   cfg_wdata = '0;
    logic [7:0]   cfg_rdata;
    logic [N-1:0] src_pend = '0, src_en = '0, src_act = '0;
    logic [N*8-1:0] src_prio = '0;
    logic         irq_req;
    logic [9:0]   irq_id;

    logic [7:0] pr [N];
    int checks = 0, failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    irq_prio_gate uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .src_pend(src_pend),
        .src_en(src_en), .src_act(src_act), .src_prio(src_prio),
        .irq_req(irq_req), .irq_id(irq_id)
    );

    // {bp written, mask, expected bp read-back}
    localparam logic [23:0] VEC [8] = '{
        {8'd0, 8'hFF, 8'd2}, {8'd1, 8'hA7, 8'd2}, {8'd2, 8'hFF, 8'd2},
        {8'd3, 8'h90, 8'd3}, {8'd4, 8'h6B, 8'd4}, {8'd5, 8'hC3, 8'd5},
        {8'd6, 8'hFE, 8'd6}, {8'd7, 8'hFF, 8'd7}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [7:0] d);
        cfg_sel = s;
        #1 d = cfg_rdata;
    endtask

    task automatic push_prio();
        for (int i = 0; i < N; i++) src_prio[i*8 +: 8] = pr[i];
    endtask

    task automatic settle();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Reference: threshold clears bits [bp:0]; strict less-than; ties keep lower index
    task automatic expect_out(input logic [7:0] mask, input int bpv, input bit de,
                              input bit ce, output int eid, output int ereq);
        logic [7:0] thr;
        int best;
        thr = mask & (8'hFF << (bpv + 1));
        best = int'(thr);
        eid = 1023;
        ereq = 0;
        for (int i = 0; i < N; i++)
            if (src_pend[i] && src_en[i] && int'(pr[i]) < best) begin
                best = int'(pr[i]);
                eid = i;
            end
        if (eid != 1023 && de && ce && !src_act[eid]) ereq = 1;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] rv;
        int eid, ereq;
        for (int i = 0; i < N; i++) pr[i] = 8'hFF;
        push_prio();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 req", int'(irq_req), 0);
        chk("R1 id", int'(irq_id), 1023);
        rd(2'd0, rv); chk("R1 ctrl", int'(rv), 0);
        rd(2'd1, rv); chk("R1 mask", int'(rv), 255);
        rd(2'd2, rv); chk("R1 bp", int'(rv), 2);

        // R10 register map
        wr(2'd3, 8'h5A);
        rd(2'd3, rv); chk("R10 sel3 reads 0", int'(rv), 0);
        rd(2'd1, rv); chk("R10 sel3 write leaves mask", int'(rv), 255);
        rd(2'd2, rv); chk("R10 sel3 write leaves bp", int'(rv), 2);
        rd(2'd0, rv); chk("R10 sel3 write leaves ctrl", int'(rv), 0);
        wr(2'd0, 8'h03);
        rd(2'd0, rv); chk("R10 ctrl", int'(rv), 3);

        // R2 only low three bits kept
        wr(2'd2, 8'h0B); rd(2'd2, rv); chk("R2 bits kept", int'(rv), 3);
        wr(2'd2, 8'hF9); rd(2'd2, rv); chk("R2 clamp high bits", int'(rv), 2);

        // Table walk: R2 clamp, R3 threshold, R4 scan against reference
        for (int v = 0; v < 8; v++) begin
            wr(2'd2, VEC[v][23:16]);
            wr(2'd1, VEC[v][15:8]);
            rd(2'd2, rv); chk("R2 readback", int'(rv), int'(VEC[v][7:0]));
            rd(2'd1, rv); chk("R10 mask readback", int'(rv), int'(VEC[v][15:8]));
            for (int r = 0; r < 20; r++) begin
                for (int i = 0; i < N; i++) pr[i] = 8'($urandom_range(0, 255));
                push_prio();
                src_pend = N'($urandom());
                src_en = N'($urandom());
                src_act = '0;
                settle();
                expect_out(VEC[v][15:8], int'(VEC[v][7:0]), 1'b1, 1'b1, eid, ereq);
                chk("R3 R4 id", int'(irq_id), eid);
                chk("R4 req", int'(irq_req), ereq);
            end
        end

        // R5 tie: mask FF, bp 2 -> threshold F8
        wr(2'd2, 8'd2); wr(2'd1, 8'hFF);
        for (int i = 0; i < N; i++) pr[i] = 8'h80;
        pr[5] = 8'h10; pr[9] = 8'h10; pr[12] = 8'h40;
        push_prio();
        src_pend = '0; src_pend[5] = 1; src_pend[9] = 1; src_pend[12] = 1;
        src_en = '1; src_act = '0;
        settle();
        chk("R5 tie id", int'(irq_id), 5);
        chk("R5 tie req", int'(irq_req), 1);

        // R3 boundary: mask 0x48, bp 4 -> threshold 0x40
        wr(2'd1, 8'h48); wr(2'd2, 8'd4);
        src_pend = '0; src_pend[3] = 1; pr[3] = 8'h40; push_prio();
        settle();
        chk("R3 equal blocked id", int'(irq_id), 1023);
        chk("R6 req low", int'(irq_req), 0);
        pr[3] = 8'h3F; push_prio();
        settle();
        chk("R3 below passes id", int'(irq_id), 3);
        chk("R3 below passes req", int'(irq_req), 1);

        // R7 enables
        wr(2'd0, 8'h02); settle();
        chk("R7 dist off req", int'(irq_req), 0);
        chk("R7 dist off id", int'(irq_id), 3);
        wr(2'd0, 8'h01); settle();
        chk("R7 cpu off req", int'(irq_req), 0);
        wr(2'd0, 8'h03); settle();
        chk("R7 both on req", int'(irq_req), 1);

        // R8 active winner
        src_act[3] = 1; settle();
        chk("R8 active req", int'(irq_req), 0);
        chk("R8 active id", int'(irq_id), 3);
        src_act[3] = 0; settle();

        // R9 one-cycle latency
        @(negedge clk);
        src_pend[3] = 0;
        #2;
        chk("R9 id held before edge", int'(irq_id), 3);
        chk("R9 req held before edge", int'(irq_req), 1);
        @(posedge clk); #1;
        chk("R9 id after edge", int'(irq_id), 1023);
        chk("R9 req after edge", int'(irq_req), 0);

        // R6 disabled source
        src_pend[3] = 1; src_en[3] = 0; settle();
        chk("R6 disabled id", int'(irq_id), 1023);

        // R3 bp 7 blocks everything
        wr(2'd1, 8'hFF); wr(2'd2, 8'd7);
        pr[3] = 8'h00; src_en[3] = 1; push_prio(); settle();
        chk("R3 bp7 id", int'(irq_id), 1023);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule